// File: doc/BRIEF.md
# TLB Access Rights Checker and Fault Encoder

This block sits after the translation lookaside buffer lookup. It receives the matched entry pair, the virtual address, the access kind and the current privilege level. From these it either forms a physical address with read, write and execute grants, or names one fault class. A fault class is turned into an exception code. The block also produces the write enables and values for the capture registers that a trap handler reads: one path for refill (no-match) faults and one path for every other fault.

The lookup, the page-table walk and trap vectoring happen elsewhere. The lookup reports `hit`, and an upstream address check reports `addr_err`. By default the results are registered, so every output appears one clock after its inputs. The parameter `REG_OUT` set to 0 makes the block purely combinational.

Each entry word uses the following layout. Bit 0 is valid. Bit 1 is dirty/writable. Bits [3:2] are the entry privilege level. Bit 4 is no-read. Bit 5 is no-execute. Bit 6 is restricted-privilege. The page frame number starts at bit 12.

Top module: `tlbchk_top`

## Requirements
- R1: Bit `vaddr[page_ps]` selects the entry: 1 selects `ent_odd` and 0 selects `ent_even`. Every check and the physical address use only the selected word.
- R2: Faults are ranked, and the highest-ranked fault is reported on `fault_cls`. The ranking, from highest, is: `addr_err` gives code 1 (address), `hit`=0 gives 2 (no-match), valid clear gives 3 (invalid), fetch with no-execute gives 4, load with no-read gives 5, privilege violation gives 6, and store with dirty clear gives 7. If no fault applies, the result is 0. Access encoding: 0 is load, 1 is store, 2 is fetch, and 3 is treated as load.
- R3: Privilege violation depends on the restricted bit. If the restricted bit is 0, a violation occurs when `cur_plv` is greater than the entry level. If the restricted bit is 1, a violation occurs when `cur_plv` differs from the entry level.
- R4: The frame-number bits from address bit 12 up to bit `page_ps`-1 are cleared. `pa` is the cleaned frame number shifted left by 12, ORed with `vaddr` bits below `page_ps`. When any fault is reported, `pa` is 0.
- R5: On success, `ok`=1 and `perm_r`=1. `perm_w` equals dirty, and `perm_x` is the inverse of no-execute. On a fault, `ok` and all three grants are 0.
- R6: When `mode64`=0, no-read, no-execute and restricted are taken as 0, and the frame number comes from entry bits [31:12] only.
- R7: No-match and invalid faults map to code 1 for a load, 2 for a store and 3 for a fetch. A no-match fault also asserts `refill_set`.
- R8: Dirty gives code 4, no-read gives 5, no-execute gives 6 and privilege gives 7. An address fault gives 8 for a fetch and 9 otherwise. On success, `exc_code` is 0.
- R9: A no-match fault asserts `rbadv_we` and `rehi_we` and sets `cap_addr`=`vaddr`. `rehi_vppn` is `vaddr[47:13]` in 64-bit mode or `vaddr[31:13]` zero-extended in 32-bit mode. `badv_we` and `ehi_we` stay 0.
- R10: Any other fault asserts `ehi_we`, with `ehi_val` = `vaddr` with bits [12:0] cleared, and sets `cap_addr`=`vaddr`. It asserts `badv_we` only when `dbg_suppress`=0. The refill outputs stay 0.
- R11: With `REG_OUT`=1, every output is 0 while `rst_n` is low. Each result appears at the first rising edge after its inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc | input | 2 | Access kind (0 load, 1 store, 2 fetch, 3 load) |
| cur_plv | input | 2 | Current privilege level |
| mode64 | input | 1 | 1 = 64-bit address mode |
| hit | input | 1 | Lookup matched an entry pair |
| addr_err | input | 1 | Upstream address error |
| dbg_suppress | input | 1 | Blocks the bad-address write for non-refill faults |
| page_ps | input | 6 | Page-size exponent of the matched pair (12..VA_W-2) |
| vaddr | input | VA_W | Virtual address |
| ent_even | input | ENT_W | Even entry word |
| ent_odd | input | ENT_W | Odd entry word |
| ok | output | 1 | Access granted |
| pa | output | PA_W | Physical address |
| perm_r | output | 1 | Read grant |
| perm_w | output | 1 | Write grant |
| perm_x | output | 1 | Execute grant |
| fault_cls | output | 3 | Fault class |
| exc_code | output | 4 | Exception code |
| refill_set | output | 1 | Set refill-in-progress flag |
| rbadv_we | output | 1 | Refill bad-address write enable |
| rehi_we | output | 1 | Refill entry-hi write enable |
| rehi_vppn | output | VA_W-13 | Refill entry-hi page-pair number |
| badv_we | output | 1 | Bad-address write enable |
| ehi_we | output | 1 | Entry-hi write enable |
| ehi_val | output | VA_W | Entry-hi value |
| cap_addr | output | VA_W | Address for the bad-address registers |

## Verification
All results come from one register stage, so each is due at the first rising edge after its inputs are applied. The bench drives a vector at a falling edge and compares every output at the next falling edge. Exactly one rising edge lies between the two, so a missing or extra stage shows up as a mismatch. The sweep covers every combination of access kind, current level, entry level, attribute bits and address mode, with several page sizes and both halves. Directed vectors cover no-match, address error and the debug-suppress flag.

// File: rtl/tlbchk_pkg.sv
package tlbchk_pkg;

  typedef enum logic [2:0] {
    FC_NONE    = 3'd0,
    FC_ADDR    = 3'd1,
    FC_NOMATCH = 3'd2,
    FC_INVALID = 3'd3,
    FC_NOEXEC  = 3'd4,
    FC_NOREAD  = 3'd5,
    FC_PRIV    = 3'd6,
    FC_DIRTY   = 3'd7
  } fault_e;

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [3:0] EC_NONE     = 4'd0;
  localparam logic [3:0] EC_PG_LOAD  = 4'd1;
  localparam logic [3:0] EC_PG_STORE = 4'd2;
  localparam logic [3:0] EC_PG_FETCH = 4'd3;
  localparam logic [3:0] EC_MODIFY   = 4'd4;
  localparam logic [3:0] EC_NOREAD   = 4'd5;
  localparam logic [3:0] EC_NOEXEC   = 4'd6;
  localparam logic [3:0] EC_PRIV     = 4'd7;
  localparam logic [3:0] EC_AE_FETCH = 4'd8;
  localparam logic [3:0] EC_AE_DATA  = 4'd9;

  localparam int BIT_V     = 0;
  localparam int BIT_D     = 1;
  localparam int BIT_PLV   = 2;
  localparam int BIT_NR    = 4;
  localparam int BIT_NX    = 5;
  localparam int BIT_RPLV  = 6;
  localparam int BIT_SWTOP = 11;
  localparam int PPN_LSB   = 12;
  localparam int PPN32_MSB = 31;

  typedef struct packed {
    logic       v;
    logic       d;
    logic [1:0] plv;
    logic       nr;
    logic       nx;
    logic       rplv;
  } attr_t;

endpackage

// File: rtl/tlbchk_half_sel.sv
module tlbchk_half_sel
  import tlbchk_pkg::*;
#(
  parameter int VA_W  = 48,
  parameter int PA_W  = 48,
  parameter int ENT_W = 64
) (
  input  logic [ENT_W-1:0] ent_even,
  input  logic [ENT_W-1:0] ent_odd,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [5:0]       page_ps,
  input  logic             mode64,
  output attr_t            attr,
  output logic [PA_W-1:0]  pa_raw
);
  localparam int PPN_W = PA_W - PPN_LSB;
  localparam int P32_W = PPN32_MSB - PPN_LSB + 1;

  logic [ENT_W-1:0] sel;
  logic [PPN_W-1:0] ppn_raw;
  logic [PPN_W-1:0] sw_mask;
  logic [VA_W-1:0]  off_mask;
  logic [5:0]       sw_sh;
  logic             unused_bits;

  always_comb begin
    sel       = vaddr[page_ps] ? ent_odd : ent_even;
    attr.v    = sel[BIT_V];
    attr.d    = sel[BIT_D];
    attr.plv  = sel[BIT_PLV +: 2];
    attr.nr   = mode64 & sel[BIT_NR];
    attr.nx   = mode64 & sel[BIT_NX];
    attr.rplv = mode64 & sel[BIT_RPLV];
    ppn_raw   = mode64 ? sel[PPN_LSB +: PPN_W]
                       : PPN_W'(sel[PPN_LSB +: P32_W]);
    sw_sh     = page_ps - 6'd12;
    sw_mask   = (PPN_W'(1) << sw_sh) - PPN_W'(1);
    off_mask  = (VA_W'(1) << page_ps) - VA_W'(1);
    pa_raw    = {ppn_raw & ~sw_mask, {PPN_LSB{1'b0}}} | PA_W'(vaddr & off_mask);
  end

  assign unused_bits = ^{sel[BIT_SWTOP:BIT_RPLV+1], sel[ENT_W-1:PPN_LSB+PPN_W]};

endmodule

// File: rtl/tlbchk_rights.sv
module tlbchk_rights
  import tlbchk_pkg::*;
(
  input  attr_t      attr,
  input  logic [1:0] acc,
  input  logic [1:0] cur_plv,
  input  logic       hit,
  input  logic       addr_err,
  output fault_e     fault,
  output logic       perm_r,
  output logic       perm_w,
  output logic       perm_x
);
  logic is_fetch, is_store, is_load, priv_bad;

  always_comb begin
    is_fetch = (acc == ACC_FETCH);
    is_store = (acc == ACC_STORE);
    is_load  = !is_fetch && !is_store;
    priv_bad = attr.rplv ? (cur_plv != attr.plv) : (cur_plv > attr.plv);

    if (addr_err)                 fault = FC_ADDR;
    else if (!hit)                fault = FC_NOMATCH;
    else if (!attr.v)             fault = FC_INVALID;
    else if (is_fetch && attr.nx) fault = FC_NOEXEC;
    else if (is_load && attr.nr)  fault = FC_NOREAD;
    else if (priv_bad)            fault = FC_PRIV;
    else if (is_store && !attr.d) fault = FC_DIRTY;
    else                          fault = FC_NONE;

    perm_r = (fault == FC_NONE);
    perm_w = perm_r && attr.d;
    perm_x = perm_r && !attr.nx;
  end

endmodule

// File: rtl/tlbchk_capture.sv
module tlbchk_capture
  import tlbchk_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int BASE_PS = 12
) (
  input  fault_e              fault,
  input  logic [1:0]          acc,
  input  logic                mode64,
  input  logic                dbg_suppress,
  input  logic [VA_W-1:0]     vaddr,
  output logic [3:0]          exc_code,
  output logic                refill_set,
  output logic                rbadv_we,
  output logic                rehi_we,
  output logic [VA_W-14:0]    rehi_vppn,
  output logic                badv_we,
  output logic                ehi_we,
  output logic [VA_W-1:0]     ehi_val,
  output logic [VA_W-1:0]     cap_addr
);
  localparam int VPPN_W = VA_W - 13;
  localparam logic [VA_W-1:0] EHI_MASK = ~((VA_W'(1) << (BASE_PS + 1)) - VA_W'(1));

  logic [3:0] pg_code;

  always_comb begin
    case (acc)
      ACC_STORE: pg_code = EC_PG_STORE;
      ACC_FETCH: pg_code = EC_PG_FETCH;
      default:   pg_code = EC_PG_LOAD;
    endcase

    case (fault)
      FC_ADDR:    exc_code = (acc == ACC_FETCH) ? EC_AE_FETCH : EC_AE_DATA;
      FC_NOMATCH,
      FC_INVALID: exc_code = pg_code;
      FC_NOEXEC:  exc_code = EC_NOEXEC;
      FC_NOREAD:  exc_code = EC_NOREAD;
      FC_PRIV:    exc_code = EC_PRIV;
      FC_DIRTY:   exc_code = EC_MODIFY;
      default:    exc_code = EC_NONE;
    endcase

    refill_set = 1'b0;
    rbadv_we   = 1'b0;
    rehi_we    = 1'b0;
    rehi_vppn  = '0;
    badv_we    = 1'b0;
    ehi_we     = 1'b0;
    ehi_val    = '0;
    cap_addr   = '0;
    if (fault == FC_NOMATCH) begin
      refill_set = 1'b1;
      rbadv_we   = 1'b1;
      rehi_we    = 1'b1;
      rehi_vppn  = mode64 ? vaddr[VA_W-1:13] : VPPN_W'(vaddr[31:13]);
      cap_addr   = vaddr;
    end else if (fault != FC_NONE) begin
      badv_we  = !dbg_suppress;
      ehi_we   = 1'b1;
      ehi_val  = vaddr & EHI_MASK;
      cap_addr = vaddr;
    end
  end

endmodule

// File: rtl/tlbchk_top.sv
module tlbchk_top
  import tlbchk_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int PA_W    = 48,
  parameter int ENT_W   = 64,
  parameter int BASE_PS = 12,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         acc,
  input  logic [1:0]         cur_plv,
  input  logic               mode64,
  input  logic               hit,
  input  logic               addr_err,
  input  logic               dbg_suppress,
  input  logic [5:0]         page_ps,
  input  logic [VA_W-1:0]    vaddr,
  input  logic [ENT_W-1:0]   ent_even,
  input  logic [ENT_W-1:0]   ent_odd,
  output logic               ok,
  output logic [PA_W-1:0]    pa,
  output logic               perm_r,
  output logic               perm_w,
  output logic               perm_x,
  output logic [2:0]         fault_cls,
  output logic [3:0]         exc_code,
  output logic               refill_set,
  output logic               rbadv_we,
  output logic               rehi_we,
  output logic [VA_W-14:0]   rehi_vppn,
  output logic               badv_we,
  output logic               ehi_we,
  output logic [VA_W-1:0]    ehi_val,
  output logic [VA_W-1:0]    cap_addr
);
  localparam int VPPN_W = VA_W - 13;

  attr_t             attr;
  logic [PA_W-1:0]   pa_raw, pa_d;
  fault_e            fault;
  logic              ok_d, r_d, w_d, x_d;
  logic [3:0]        exc_d;
  logic              refill_d, rbadv_d, rehi_d, badv_d, ehi_d;
  logic [VPPN_W-1:0] vppn_d;
  logic [VA_W-1:0]   ehi_val_d, cap_d;

  tlbchk_half_sel #(.VA_W(VA_W), .PA_W(PA_W), .ENT_W(ENT_W)) u_half (
    .ent_even(ent_even), .ent_odd(ent_odd), .vaddr(vaddr), .page_ps(page_ps),
    .mode64(mode64), .attr(attr), .pa_raw(pa_raw)
  );

  tlbchk_rights u_rights (
    .attr(attr), .acc(acc), .cur_plv(cur_plv), .hit(hit), .addr_err(addr_err),
    .fault(fault), .perm_r(r_d), .perm_w(w_d), .perm_x(x_d)
  );

  tlbchk_capture #(.VA_W(VA_W), .BASE_PS(BASE_PS)) u_cap (
    .fault(fault), .acc(acc), .mode64(mode64), .dbg_suppress(dbg_suppress),
    .vaddr(vaddr), .exc_code(exc_d), .refill_set(refill_d), .rbadv_we(rbadv_d),
    .rehi_we(rehi_d), .rehi_vppn(vppn_d), .badv_we(badv_d), .ehi_we(ehi_d),
    .ehi_val(ehi_val_d), .cap_addr(cap_d)
  );

  always_comb begin
    ok_d = (fault == FC_NONE);
    pa_d = ok_d ? pa_raw : '0;
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ok <= 1'b0; pa <= '0; perm_r <= 1'b0; perm_w <= 1'b0; perm_x <= 1'b0;
          fault_cls <= 3'd0; exc_code <= 4'd0; refill_set <= 1'b0;
          rbadv_we <= 1'b0; rehi_we <= 1'b0; rehi_vppn <= '0;
          badv_we <= 1'b0; ehi_we <= 1'b0; ehi_val <= '0; cap_addr <= '0;
        end else begin
          ok <= ok_d; pa <= pa_d; perm_r <= r_d; perm_w <= w_d; perm_x <= x_d;
          fault_cls <= fault; exc_code <= exc_d; refill_set <= refill_d;
          rbadv_we <= rbadv_d; rehi_we <= rehi_d; rehi_vppn <= vppn_d;
          badv_we <= badv_d; ehi_we <= ehi_d; ehi_val <= ehi_val_d; cap_addr <= cap_d;
        end
      end
    end else begin : g_comb
      always_comb begin
        ok = ok_d; pa = pa_d; perm_r = r_d; perm_w = w_d; perm_x = x_d;
        fault_cls = fault; exc_code = exc_d; refill_set = refill_d;
        rbadv_we = rbadv_d; rehi_we = rehi_d; rehi_vppn = vppn_d;
        badv_we = badv_d; ehi_we = ehi_d; ehi_val = ehi_val_d; cap_addr = cap_d;
      end
    end
  endgenerate

  AST_WRITE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    perm_w |-> (perm_r && ok)); // R5
  AST_GRANT_ONLY_ON_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_r || perm_w || perm_x) |-> ok); // R5
  AST_FAULT_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_cls != 3'd0) |-> (exc_code != 4'd0 && !ok)); // R8
  AST_REFILL_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    refill_set |-> (rbadv_we && rehi_we && !ehi_we && !badv_we)); // R9
  AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rehi_we && ehi_we)); // R10
  AST_EHI_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ehi_we |-> (ehi_val[BASE_PS:0] == '0)); // R10
  AST_PA_CLEAR_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !ok |-> (pa == '0)); // R4

endmodule

// File: tb/tlbchk_top_tb.sv
module tlbchk_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W = 48;
  localparam int PA_W = 48;
  localparam int ENT_W = 64;
  localparam int VPPN_W = VA_W - 13;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] acc, cur_plv;
  logic mode64, hit, addr_err, dbg_suppress;
  logic [5:0] page_ps;
  logic [VA_W-1:0] vaddr;
  logic [ENT_W-1:0] ent_even, ent_odd;
  logic ok, perm_r, perm_w, perm_x, refill_set, rbadv_we, rehi_we, badv_we, ehi_we;
  logic [PA_W-1:0] pa;
  logic [2:0] fault_cls;
  logic [3:0] exc_code;
  logic [VPPN_W-1:0] rehi_vppn;
  logic [VA_W-1:0] ehi_val, cap_addr;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlbchk_top dut_i (
    .clk(clk), .rst_n(rst_n), .acc(acc), .cur_plv(cur_plv), .mode64(mode64),
    .hit(hit), .addr_err(addr_err), .dbg_suppress(dbg_suppress), .page_ps(page_ps),
    .vaddr(vaddr), .ent_even(ent_even), .ent_odd(ent_odd), .ok(ok), .pa(pa),
    .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x), .fault_cls(fault_cls),
    .exc_code(exc_code), .refill_set(refill_set), .rbadv_we(rbadv_we),
    .rehi_we(rehi_we), .rehi_vppn(rehi_vppn), .badv_we(badv_we), .ehi_we(ehi_we),
    .ehi_val(ehi_val), .cap_addr(cap_addr)
  );

  task automatic chk(input string req, input string what, input logic [63:0] got,
                     input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // Drive at a falling edge, compare at the next falling edge (one rising edge: R11).
  task automatic run_vec(input string req, input logic [1:0] a, input logic [1:0] plv,
                         input logic m64, input logic h, input logic ae, input logic dbg,
                         input logic [5:0] ps, input logic [47:0] va,
                         input logic [63:0] ev, input logic [63:0] od);
    logic [63:0] s;
    logic v, d, nr, nx, rp, pbad, ld, st, fe;
    logic [1:0] eplv;
    logic [35:0] ppn;
    logic [47:0] epa;
    logic [2:0] efc;
    logic [3:0] eec, pgc;
    logic eok;
    acc = a; cur_plv = plv; mode64 = m64; hit = h; addr_err = ae; dbg_suppress = dbg;
    page_ps = ps; vaddr = va; ent_even = ev; ent_odd = od;
    s = va[ps] ? od : ev;
    v = s[0]; d = s[1]; eplv = s[3:2];
    nr = m64 & s[4]; nx = m64 & s[5]; rp = m64 & s[6];
    ppn = m64 ? s[47:12] : {16'b0, s[31:12]};
    ppn = ppn & ~((36'd1 << (ps - 6'd12)) - 36'd1);
    fe = (a == 2'd2); st = (a == 2'd1); ld = !fe && !st;
    pbad = rp ? (plv != eplv) : (plv > eplv);
    if (ae) efc = 3'd1;
    else if (!h) efc = 3'd2;
    else if (!v) efc = 3'd3;
    else if (fe && nx) efc = 3'd4;
    else if (ld && nr) efc = 3'd5;
    else if (pbad) efc = 3'd6;
    else if (st && !d) efc = 3'd7;
    else efc = 3'd0;
    eok = (efc == 3'd0);
    epa = eok ? ({ppn, 12'b0} | (va & ((48'd1 << ps) - 48'd1))) : 48'd0;
    pgc = st ? 4'd2 : (fe ? 4'd3 : 4'd1);
    case (efc)
      3'd1: eec = fe ? 4'd8 : 4'd9;
      3'd2, 3'd3: eec = pgc;
      3'd4: eec = 4'd6;
      3'd5: eec = 4'd5;
      3'd6: eec = 4'd7;
      3'd7: eec = 4'd4;
      default: eec = 4'd0;
    endcase
    @(negedge clk);
    chk({req, "/R2"}, "fault_cls", 64'(fault_cls), 64'(efc));
    chk({req, "/R4"}, "pa", 64'(pa), 64'(epa));
    chk({req, "/R5"}, "ok", 64'(ok), 64'(eok));
    chk({req, "/R5"}, "perms", 64'({perm_r, perm_w, perm_x}),
        64'({eok, eok & d, eok & !nx}));
    chk((efc == 3'd2 || efc == 3'd3) ? {req, "/R7"} : {req, "/R8"}, "exc_code",
        64'(exc_code), 64'(eec));
    chk({req, "/R9"}, "refill", 64'({refill_set, rbadv_we, rehi_we}),
        (efc == 3'd2) ? 64'd7 : 64'd0);
    chk({req, "/R9"}, "rehi_vppn", 64'(rehi_vppn),
        (efc != 3'd2) ? 64'd0 : (m64 ? 64'(va[47:13]) : 64'(va[31:13])));
    chk({req, "/R10"}, "badv_we/ehi_we", 64'({badv_we, ehi_we}),
        (efc == 3'd0 || efc == 3'd2) ? 64'd0 : 64'({!dbg, 1'b1}));
    chk({req, "/R10"}, "ehi_val", 64'(ehi_val),
        (efc == 3'd0 || efc == 3'd2) ? 64'd0 : 64'(va & ~48'h1FFF));
    chk({req, "/R10"}, "cap_addr", 64'(cap_addr), eok ? 64'd0 : 64'(va));
  endtask

  function automatic logic [63:0] mk_ent(input logic [6:0] attr, input logic [35:0] ppn);
    return {16'h0, ppn, 5'b0, attr};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [5:0] ps_tab [5];
    int k;
    ps_tab[0] = 6'd12; ps_tab[1] = 6'd13; ps_tab[2] = 6'd14;
    ps_tab[3] = 6'd21; ps_tab[4] = 6'd30;
    k = 0;
    rst_n = 1'b0; acc = 2'd0; cur_plv = 2'd0; mode64 = 1'b1; hit = 1'b1;
    addr_err = 1'b0; dbg_suppress = 1'b0; page_ps = 6'd12; vaddr = '1;
    ent_even = '1; ent_odd = '1;
    repeat (3) @(negedge clk);
    // R11: reset state of all outputs.
    chk("R11", "reset flags", 64'({ok, perm_r, perm_w, perm_x, refill_set, rbadv_we,
        rehi_we, badv_we, ehi_we, fault_cls, exc_code}), 64'd0);
    chk("R11", "reset values", 64'(pa | ehi_val | cap_addr | 48'(rehi_vppn)), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Exhaustive attribute sweep; label R6 in 32-bit mode, R3 otherwise.
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 3; a++)
        for (int pl = 0; pl < 4; pl++)
          for (int ep = 0; ep < 4; ep++)
            for (int at = 0; at < 32; at++) begin
              logic [6:0] bits, other;
              logic [35:0] p0, p1;
              logic [47:0] va;
              bits = {at[4], at[3], at[2], 2'(ep), at[1], at[0]};
              other = ~bits;
              p0 = {$urandom, $urandom} ;
              p1 = {$urandom, $urandom};
              va = {$urandom, $urandom};
              if (m[0]) va = va; else va = {16'h0, va[31:0]};
              k++;
              if (va[ps_tab[k % 5]])
                run_vec(m[0] ? "R3" : "R6", 2'(a), 2'(pl), m[0], 1'b1, 1'b0, k[3],
                        ps_tab[k % 5], va, mk_ent(other, p1), mk_ent(bits, p0));
              else
                run_vec(m[0] ? "R3" : "R6", 2'(a), 2'(pl), m[0], 1'b1, 1'b0, k[3],
                        ps_tab[k % 5], va, mk_ent(bits, p0), mk_ent(other, p1));
            end

    // R1: same entries, address bit PS flips the selected half.
    for (int h = 0; h < 2; h++) begin
      logic [47:0] va;
      va = 48'h1234_5678_9ABC;
      va[16] = h[0];
      run_vec("R1", 2'd1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 6'd16, va,
              mk_ent(7'b0000011, 36'hAAAAAAAAA), mk_ent(7'b0000001, 36'h555555555));
    end
    // R7 / R9: no-match for each access kind and mode.
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 4; a++)
        run_vec("R7", 2'(a), 2'd0, m[0], 1'b0, 1'b0, a[0], 6'd12,
                48'hFEDC_BA98_7654, '1, '1);
    // R8: address error outranks a miss.
    for (int a = 0; a < 4; a++)
      run_vec("R8", 2'(a), 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 6'd14,
              48'h8000_0000_1FFF, '0, '0);
    // R10: debug-suppress on an invalid fault.
    for (int dbg = 0; dbg < 2; dbg++)
      run_vec("R10", 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, dbg[0], 6'd12,
              48'h0000_0ABC_DEF0, '0, '0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule